// File: doc/BRIEF.md
# Clock Unit Control Register Bank

This block holds the configuration registers of a clock unit that drives four PLLs. A simple bus reads and writes them: a byte address, a write strobe, 32-bit write data and registered 32-bit read data. Every write carries its own bit mask in its upper half-word. Bit i of the lower half-word is changed only when bit i+16 of the same write is set. Software can therefore change one field with a single write and no read-modify-write. The stored values also drive the PLLs directly through dedicated output ports.

Each PLL has a block of four registers: a divider word (output and reference dividers), a feedback divider word, a bandwidth-adjust word, and a control word with reset and bypass bits. One shared mode register holds a 2-bit operating mode for each PLL. A read-only status word gathers the per-PLL lock inputs at fixed bit positions. Only the bits that belong to a defined field are stored. All other bits read as zero.

Top module: `clk_ctl_regs`

## Requirements
- R1: On a write to a mapped register, bit i (0..15) of the stored value takes write-data bit i only when write-data bit i+16 is 1. Otherwise it keeps its old value.
- R2: PLL p (0..3) owns four word registers at byte addresses 0x10*p + 0x0, +0x4, +0x8 and +0xC. Each is written and read on its own.
- R3: In the first word of a PLL, bits [3:0] hold the output divider code and bits [13:8] hold the reference divider code. These bits drive `pll_out_div[4p+:4]` and `pll_ref_div[6p+:6]`. All other bits read zero.
- R4: In the second word, bits [12:0] hold the feedback divider code and drive `pll_fb_div[13p+:13]`. In the third word, bits [11:0] hold the bandwidth code and drive `pll_bw_adj[12p+:12]`. All other bits read zero.
- R5: In the fourth word, bit 1 drives `pll_rst[p]` and bit 0 drives `pll_bypass[p]`. All other bits read zero.
- R6: The mode register at 0x40 holds a 2-bit field for PLL p at bits [4p+1:4p]. The field drives `pll_mode[2p+:2]`, with 0 = slow, 1 = normal and 2 = deep slow. All other bits read zero.
- R7: The status word at 0x44 returns `lock_in[0]`, `lock_in[1]`, `lock_in[2]` and `lock_in[3]` at bits 6, 5, 7 and 8, with every other bit zero. Writes to 0x44 have no effect.
- R8: Bits [31:16] of every read return zero.
- R9: A write to an address that is not a mapped register changes nothing. This covers addresses with nonzero bits [1:0] and word addresses above 0x44. A read from such an address returns zero.
- R10: After reset, every stored bit is zero: all PLLs are in slow mode, with reset and bypass deasserted and all divider codes zero.
- R11: `rd_data` is registered. It shows the register addressed at the previous clock edge, with the value that register held before any write at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Upper half is bit mask, lower half is data |
| rd_data | output | 32 | Registered read data |
| lock_in | input | 4 | Per-PLL lock flags |
| pll_out_div | output | 16 | Output divider codes, 4 bits per PLL |
| pll_ref_div | output | 24 | Reference divider codes, 6 bits per PLL |
| pll_fb_div | output | 52 | Feedback divider codes, 13 bits per PLL |
| pll_bw_adj | output | 48 | Bandwidth codes, 12 bits per PLL |
| pll_rst | output | 4 | PLL reset controls |
| pll_bypass | output | 4 | PLL bypass controls |
| pll_mode | output | 8 | Mode fields, 2 bits per PLL |

## Verification
The assertions take for granted that `addr`, `wr_en` and `wr_data` are stable and known at every clock edge while reset is low. They also assume that `lock_in` changes only between edges, so a status read reflects the value present at the capturing edge. The bench drives every input on the falling edge, and holds `lock_in` constant across each status read. It also keeps `wr_en` low during pure reads, so that each read-back samples a single known model state.

// File: rtl/clk_ctl_pkg.sv
package clk_ctl_pkg;
  localparam int NUM_PLL   = 4;
  localparam int HW        = 16;
  localparam int DW        = 2 * HW;
  localparam int REGS_PER  = 4;
  localparam int MODE_IDX  = NUM_PLL * REGS_PER;
  localparam int STAT_IDX  = MODE_IDX + 1;
  localparam int NREG      = MODE_IDX + 1;
  localparam int OD_W      = 4;
  localparam int RD_W      = 6;
  localparam int RD_LSB    = 8;
  localparam int FB_W      = 13;
  localparam int BW_W      = 12;
  localparam int MODE_W    = 2;
  localparam int MODE_STEP = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_SLOW = 2'd0,
    MODE_NORM = 2'd1,
    MODE_DEEP = 2'd2
  } pll_mode_e;

  // Bits that hold state in word r of the writable map
  function automatic logic [HW-1:0] store_mask(input int r);
    logic [HW-1:0] m;
    m = '0;
    if (r == MODE_IDX) begin
      for (int p = 0; p < NUM_PLL; p++)
        m[p*MODE_STEP +: MODE_W] = '1;
    end else if (r < MODE_IDX) begin
      case (r % REGS_PER)
        0: begin
          m[OD_W-1:0] = '1;
          m[RD_LSB +: RD_W] = '1;
        end
        1: m[FB_W-1:0] = '1;
        2: m[BW_W-1:0] = '1;
        default: m[1:0] = 2'b11;
      endcase
    end
    return m;
  endfunction

  // Position of each PLL's lock flag in the status word
  function automatic int lock_pos(input int p);
    case (p)
      0: return 6;
      1: return 5;
      2: return 7;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/clk_ctl_mreg.sv
module clk_ctl_mreg #(
  parameter int HW = 16,
  parameter logic [HW-1:0] STORE_MASK = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic [2*HW-1:0] wdata,
  output logic [HW-1:0] q
);
  genvar b;
  generate
    for (b = 0; b < HW; b++) begin : g_bit
      if (STORE_MASK[b]) begin : g_ff
        logic q_r;
        always_ff @(posedge clk) begin
          if (rst)
            q_r <= 1'b0;
          else if (sel && wdata[HW+b])
            q_r <= wdata[b];
        end
        assign q[b] = q_r;
      end else begin : g_zero
        assign q[b] = 1'b0;
      end
    end
  endgenerate

  // R1
  keep_unselected_chk: assert property (@(posedge clk) disable iff (rst)
    sel |=> ((q ^ $past(q)) & ~$past(wdata[2*HW-1:HW])) == '0);
  // R1
  take_selected_chk: assert property (@(posedge clk) disable iff (rst)
    sel |=> ((q ^ $past(wdata[HW-1:0])) & $past(wdata[2*HW-1:HW]) & STORE_MASK) == '0);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sel |=> $stable(q));
endmodule

// File: rtl/clk_ctl_rdmux.sv
module clk_ctl_rdmux #(
  parameter int HW    = 16,
  parameter int NREG  = 17,
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx,
  input  logic              aligned,
  input  logic [NREG*HW-1:0] regs_flat,
  input  logic [HW-1:0]     status_word,
  output logic [2*HW-1:0]   rd_data
);
  logic [HW-1:0] nxt;

  always_comb begin
    nxt = '0;
    if (aligned) begin
      for (int r = 0; r < NREG; r++)
        if (idx == IDX_W'(r)) nxt = regs_flat[r*HW +: HW];
      if (idx == IDX_W'(NREG)) nxt = status_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= {{HW{1'b0}}, nxt};
  end

  // R9
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(aligned) || ($past(idx) > IDX_W'(NREG))) |-> rd_data == '0);
endmodule

// File: rtl/clk_ctl_regs.sv
module clk_ctl_regs
  import clk_ctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wr_en,
  input  logic [DW-1:0]           wr_data,
  output logic [DW-1:0]           rd_data,
  input  logic [NUM_PLL-1:0]      lock_in,
  output logic [NUM_PLL*OD_W-1:0] pll_out_div,
  output logic [NUM_PLL*RD_W-1:0] pll_ref_div,
  output logic [NUM_PLL*FB_W-1:0] pll_fb_div,
  output logic [NUM_PLL*BW_W-1:0] pll_bw_adj,
  output logic [NUM_PLL-1:0]      pll_rst,
  output logic [NUM_PLL-1:0]      pll_bypass,
  output logic [NUM_PLL*MODE_W-1:0] pll_mode
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]   word_idx;
  logic               aligned;
  logic [NREG*HW-1:0] regs_flat;
  logic [HW-1:0]      status_word;

  assign word_idx = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);

  genvar r, p;
  generate
    for (r = 0; r < NREG; r++) begin : g_reg
      logic sel;
      assign sel = wr_en && aligned && (word_idx == IDX_W'(r));
      clk_ctl_mreg #(.HW(HW), .STORE_MASK(store_mask(r))) u_reg (
        .clk   (clk),
        .rst   (rst),
        .sel   (sel),
        .wdata (wr_data),
        .q     (regs_flat[r*HW +: HW])
      );
    end

    for (p = 0; p < NUM_PLL; p++) begin : g_pll
      localparam int B = p * REGS_PER * HW;
      assign pll_out_div[p*OD_W +: OD_W] = regs_flat[B +: OD_W];
      assign pll_ref_div[p*RD_W +: RD_W] = regs_flat[B + RD_LSB +: RD_W];
      assign pll_fb_div[p*FB_W +: FB_W]  = regs_flat[B + HW +: FB_W];
      assign pll_bw_adj[p*BW_W +: BW_W]  = regs_flat[B + 2*HW +: BW_W];
      assign pll_rst[p]    = regs_flat[B + 3*HW + 1];
      assign pll_bypass[p] = regs_flat[B + 3*HW];
      assign pll_mode[p*MODE_W +: MODE_W] =
        regs_flat[MODE_IDX*HW + p*MODE_STEP +: MODE_W];
    end
  endgenerate

  always_comb begin
    status_word = '0;
    for (int i = 0; i < NUM_PLL; i++)
      status_word[lock_pos(i)] = lock_in[i];
  end

  clk_ctl_rdmux #(.HW(HW), .NREG(NREG), .IDX_W(IDX_W)) u_rdmux (
    .clk         (clk),
    .rst         (rst),
    .idx         (word_idx),
    .aligned     (aligned),
    .regs_flat   (regs_flat),
    .status_word (status_word),
    .rd_data     (rd_data)
  );

  // R10
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pll_mode == '0 && pll_rst == '0 && pll_bypass == '0 &&
                    pll_out_div == '0 && pll_fb_div == '0));
  // R7
  lock_layout_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(aligned) && $past(word_idx) == IDX_W'(STAT_IDX)) |->
      (rd_data[4:0] == '0 && rd_data[DW-1:9] == '0));
endmodule

// File: tb/tb_clk_ctl_regs.sv
module tb_clk_ctl_regs;
  localparam int ADDR_W = 8;
  localparam int NW = 1 << (ADDR_W - 2);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  lock_in = '0;
  logic [15:0] pll_out_div;
  logic [23:0] pll_ref_div;
  logic [51:0] pll_fb_div;
  logic [47:0] pll_bw_adj;
  logic [3:0]  pll_rst, pll_bypass;
  logic [7:0]  pll_mode;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [15:0] mdl [17];
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  clk_ctl_regs #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .lock_in(lock_in), .pll_out_div(pll_out_div),
    .pll_ref_div(pll_ref_div), .pll_fb_div(pll_fb_div), .pll_bw_adj(pll_bw_adj),
    .pll_rst(pll_rst), .pll_bypass(pll_bypass), .pll_mode(pll_mode)
  );

  function automatic logic [15:0] smask(input int r);
    case (r)
      16: return 16'h3333;
      default:
        if (r > 16) return 16'h0;
        else case (r % 4)
          0: return 16'h3F0F;
          1: return 16'h1FFF;
          2: return 16'h0FFF;
          default: return 16'h0003;
        endcase
    endcase
  endfunction

  function automatic logic [15:0] lock_word(input logic [3:0] v);
    int pos [4] = '{6, 5, 7, 8};
    logic [15:0] w = '0;
    for (int i = 0; i < 4; i++) w[pos[i]] = v[i];
    return w;
  endfunction

  function automatic logic [15:0] exp_read(input int a);
    if (a % 4 != 0) return 16'h0;
    if (a / 4 < 17) return mdl[a/4];
    if (a / 4 == 17) return lock_word(lock_in);
    return 16'h0;
  endfunction

  function automatic string tag_of(input int a);
    if (a % 4 != 0 || a / 4 > 17) return "R9";
    if (a / 4 == 16) return "R6";
    if (a / 4 == 17) return "R7";
    case ((a / 4) % 4)
      0: return "R3";
      3: return "R5";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [31:0] next_rand();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = ADDR_W'(a); wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a % 4 == 0 && a / 4 < 17) begin
      logic [15:0] m;
      m = d[31:16] & smask(a / 4);
      mdl[a/4] = (mdl[a/4] & ~m) | (d[15:0] & m);
    end
  endtask

  task automatic rd_chk(input int a, input string tag);
    @(negedge clk);
    addr = ADDR_W'(a); wr_en = 1'b0;
    @(negedge clk);
    chk(tag, rd_data, {16'h0, exp_read(a)});
  endtask

  task automatic out_chk();
    logic [15:0] e_od; logic [23:0] e_rd; logic [51:0] e_fb; logic [47:0] e_bw;
    logic [3:0] e_rs, e_by; logic [7:0] e_md;
    for (int p = 0; p < 4; p++) begin
      e_od[4*p +: 4]   = mdl[4*p][3:0];
      e_rd[6*p +: 6]   = mdl[4*p][13:8];
      e_fb[13*p +: 13] = mdl[4*p+1][12:0];
      e_bw[12*p +: 12] = mdl[4*p+2][11:0];
      e_rs[p]          = mdl[4*p+3][1];
      e_by[p]          = mdl[4*p+3][0];
      e_md[2*p +: 2]   = mdl[16][4*p +: 2];
    end
    chk("R3 out_div", pll_out_div, e_od);
    chk("R3 ref_div", pll_ref_div, e_rd);
    chk("R4 fb_div", pll_fb_div, e_fb);
    chk("R4 bw_adj", pll_bw_adj, e_bw);
    chk("R5 rst", pll_rst, e_rs);
    chk("R5 bypass", pll_bypass, e_by);
    chk("R6 mode", pll_mode, e_md);
  endtask

  task automatic readback_all(input string tag);
    for (int w = 0; w < NW; w++) rd_chk(w * 4, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 17; i++) mdl[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R10: reset state at ports and through reads
    chk("R10 mode", pll_mode, 0);
    chk("R10 rst", pll_rst, 0);
    chk("R10 bypass", pll_bypass, 0);
    chk("R10 rd_data", rd_data, 0);
    out_chk();
    readback_all("R10");

    // R2..R6, R8: patterned writes to every word address
    for (int w = 0; w < NW; w++) begin
      for (int k = 0; k < 4; k++) begin
        wr(w * 4, next_rand());
        rd_chk(w * 4, tag_of(w * 4));
        chk("R8", rd_data[31:16], 0);
        out_chk();
      end
    end
    // R2: each PLL word holds its own value
    for (int r = 0; r < 16; r++) wr(r * 4, {16'hFFFF, 16'(r * 16'h0111 + 16'h0A05)});
    readback_all("R2");
    out_chk();

    // R1: single-bit mask sweep, setting then clearing each bit
    for (int r = 0; r < 17; r++) begin
      wr(r * 4, 32'hFFFF_0000);
      for (int b = 0; b < 16; b++) begin
        wr(r * 4, {16'(1 << b), 16'hFFFF});
        rd_chk(r * 4, "R1");
      end
      for (int b = 0; b < 16; b++) begin
        wr(r * 4, {16'(1 << b), 16'h0000});
        rd_chk(r * 4, "R1");
      end
      wr(r * 4, {16'h0000, 16'hFFFF});
      rd_chk(r * 4, "R1");
      wr(r * 4, next_rand());
    end
    out_chk();

    // R6: each encoding in each field
    for (int p = 0; p < 4; p++)
      for (int e = 0; e < 3; e++) begin
        wr(16'h40, {16'(3 << (4 * p)), 16'(e << (4 * p))});
        chk("R6 field", pll_mode[2*p +: 2], e);
      end

    // R7: every lock pattern, and a write that must not stick
    for (int v = 0; v < 16; v++) begin
      @(negedge clk) lock_in = 4'(v);
      rd_chk(16'h44, "R7");
    end
    lock_in = 4'b0101;
    wr(16'h44, 32'hFFFF_FFFF);
    rd_chk(16'h44, "R7");
    readback_all("R7");

    // R9: misaligned and out-of-map writes change nothing
    for (int w = 0; w < NW; w++) begin
      wr(w * 4 + 1 + (w % 3), 32'hFFFF_FFFF);
      if (w > 17) wr(w * 4, 32'hFFFF_FFFF);
    end
    readback_all("R9");
    out_chk();
    rd_chk(16'h02, "R9");

    // R11: read and write to the same word at the same edge
    begin
      logic [15:0] old_v;
      wr(16'h10, 32'hFFFF_0000);
      old_v = mdl[4];
      @(negedge clk);
      addr = 8'h10; wr_en = 1'b1; wr_data = 32'h000F_000A;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R11 old", rd_data, {16'h0, old_v});
      mdl[4] = (mdl[4] & ~16'h000F) | 16'h000A;
      @(negedge clk);
      chk("R11 new", rd_data, {16'h0, mdl[4]});
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule